// File: doc/BRIEF.md
# Boundary Register Test-Operation Engine

This block is the data side of a boundary-scan cell chain. It has a chain of shift stages, one per device pin. Each stage has a shadow latch behind it, and the shadow latches drive the pins. A small control register selects the self-test operation to run. The test access port controller sits outside the block and supplies the current TAP state code. The instruction decoder also sits outside and supplies an instruction code. The block uses these two codes to pick the register between `tdi` and `tdo`. It also uses them to decide what happens on each test clock edge.

The cells split into two segments. The lower `N_IN` cells form the input segment, which gathers signatures. The upper `N_OUT` cells form the output segment, which generates patterns or counts. A per-cell direction flag marks each cell as output-mode or input-mode. The sample/toggle operation and the toggle instruction use these flags.

Shift stages change on rising `tck`, and shadow latches change on falling `tck`. While the TAP sits in Run-Test/Idle, each rising edge advances the selected operation one step in the shift stages. The falling edge that follows copies the result to the shadow latches, so the pins follow the engine every cycle.

Top module: `boundary_test_engine`

## Requirements
- R1: A low `rst_n` on a rising edge clears every shift stage, the bypass stage and the control register. A low `rst_n` on a falling edge clears every shadow latch and the latched operation. After reset `pin_out` is 0 and `tdo` is 0.
- R2: The boundary register sits between `tdi` and `tdo` for instruction codes 1 (sample), 2 (read) and 3 (self-test). The control register sits there for code 6. A one-bit bypass stage sits there for all other codes. In TAP state 4'h2 (Shift-DR) the selected register shifts toward bit 0: `tdi` enters the highest bit and `tdo` shows bit 0.
- R3: In TAP state 4'h6 (Capture-DR), each instruction loads the shift stages as follows. Sample loads `pin_in`. Read leaves the stages unchanged. Self-test loads the inverse of the shadow latches. The bypass stage loads 0.
- R4: In TAP state 4'h5 (Update-DR) with the boundary register selected, the falling edge copies the shift stages to the shadow latches. Otherwise the shadow latches change only in Run-Test/Idle under code 4 or 5.
- R5: The control register is 3 bits wide. A Capture-DR leaves it unchanged. An Update-DR under code 6 latches it as the operation. Operation codes: 0 sample/toggle, 1 pattern generation, 2 signature, 3 signature plus pattern, 4 signature plus count. Codes 5 to 7 do nothing.
- R6: Pattern generation (op 1 or 3) steps the output segment S (bits N-1..N_IN) to {S[W-2:0], XOR of S masked by the tap set}. For W=8 the tap set is bits 7, 5, 4 and 3. Under op 1 the input segment holds.
- R7: Signature analysis (op 2, 3, 4) steps the input segment T (bits N_IN-1..0) to the same shift with feedback, XORed with `pin_in[N_IN-1:0]`. Under op 2 the output segment holds.
- R8: Op 3 applies R6 to the output segment and R7 to the input segment on the same edge.
- R9: Op 4 adds 1 to the output segment on each step and wraps from all-ones to zero, while the input segment follows R7.
- R10: Op 0 inverts each cell whose `cell_dir` bit is 1 and loads `pin_in` into each cell whose bit is 0.
- R11: Instruction code 5 (toggle) inverts each cell whose `cell_dir` bit is 1 on each Run-Test/Idle edge. Cells whose bit is 0 hold their value whatever `pin_in` does.
- R12: Under code 4 with a valid operation, or under code 5, each falling edge in Run-Test/Idle (TAP state 4'hC) copies the shift stages to the shadow latches. `pin_out` therefore shows the new step in the same cycle.
- R13: Shift stages do not change in any TAP state other than Capture-DR, Shift-DR and Run-Test/Idle. In Run-Test/Idle nothing changes under codes other than 4 or 5, or under code 4 with operation 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift stages on rising, shadows on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_state | input | 4 | Current TAP state code (4'hC idle, 4'h6 capture, 4'h2 shift, 4'h5 update) |
| instr | input | 3 | Decoded instruction code |
| tdi | input | 1 | Serial test data in |
| pin_in | input | N_IN+N_OUT | Values seen at the device pins |
| cell_dir | input | N_IN+N_OUT | Per-cell mode: 1 output-mode, 0 input-mode |
| pin_out | output | N_IN+N_OUT | Shadow latch values driving the pins |
| tdo | output | 1 | Serial test data out, bit 0 of the selected register |

## Verification
Errors in the shift stages or in a pattern or signature step appear on `pin_out` on the falling edge of the same Run-Test/Idle cycle. A later read-out scan then shows them again. An error in a signature step never cancels out, so it stays in the final read-out. A wrong latched operation shows on the first Run-Test/Idle cycle after the run instruction. A mistake in the capture or shift path appears on `tdo` within the scan that follows, bit by bit in shift order.

// File: rtl/bte_pkg.sv
// Shared codes for the boundary test engine: TAP state codes, instruction
// codes, operation codes and the maximal-length tap masks.
// Assumes the external TAP controller uses the standard four-bit state codes.
package bte_pkg;

    localparam logic [3:0] TAP_RUN_IDLE = 4'hC;
    localparam logic [3:0] TAP_CAPTURE  = 4'h6;
    localparam logic [3:0] TAP_SHIFT    = 4'h2;
    localparam logic [3:0] TAP_UPDATE   = 4'h5;

    localparam logic [2:0] INS_BYPASS   = 3'd0;
    localparam logic [2:0] INS_SAMPLE   = 3'd1;
    localparam logic [2:0] INS_READ     = 3'd2;
    localparam logic [2:0] INS_SELFTEST = 3'd3;
    localparam logic [2:0] INS_RUN      = 3'd4;
    localparam logic [2:0] INS_TOGGLE   = 3'd5;
    localparam logic [2:0] INS_CTRL     = 3'd6;

    localparam int         OP_W         = 3;
    localparam logic [2:0] OP_SIPTOG    = 3'd0;
    localparam logic [2:0] OP_PATGEN    = 3'd1;
    localparam logic [2:0] OP_SIG       = 3'd2;
    localparam logic [2:0] OP_SIG_PAT   = 3'd3;
    localparam logic [2:0] OP_SIG_CNT   = 3'd4;

    // Feedback tap mask of a maximal-length left-shifting LFSR of width w.
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0E08;
            16:      return 32'h0000_B400;
            default: return 32'h0000_00B8;
        endcase
    endfunction

endpackage

// File: rtl/bte_ctrl_reg.sv
// Control register: a W-bit shift stage scanned from tdi. The operation latch
// behind it loads on the falling edge of Update-DR.
// Assumes sel is high only while the control-register instruction is active.
module bte_ctrl_reg #(
    parameter int W = 3
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         sh,
    input  logic         upd,
    input  logic         tdi,
    output logic [W-1:0] shift_q,
    output logic [W-1:0] op_q
);

    // Shift stage: moves toward bit 0 in Shift-DR, holds otherwise.
    always_ff @(posedge tck) begin
        if (!rst_n)
            shift_q <= '0;
        else if (sel && sh)
            shift_q <= {tdi, shift_q[W-1:1]};
    end

    // Operation latch: takes the scanned value on the falling edge of Update-DR.
    always_ff @(negedge tck) begin
        if (!rst_n)
            op_q <= '0;
        else if (sel && upd)
            op_q <= shift_q;
    end

endmodule

// File: rtl/bte_lfsr_step.sv
// One combinational step of a left-shifting Fibonacci LFSR.
// The inject vector is XORed into the result, which turns the step into a
// parallel signature compressor. Tie inject to zero for pure pattern
// generation.
module bte_lfsr_step #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] inject,
    output logic [W-1:0] next
);

    logic fb;

    // Feedback bit and shifted result with injected data.
    always_comb begin
        fb   = ^(state & TAPS);
        next = {state[W-2:0], fb} ^ inject;
    end

endmodule

// File: rtl/bte_run_logic.sv
// Next shift-stage values for one Run-Test/Idle step. Segments are fixed by
// position: the input segment is the low N_IN cells and the output segment is
// the high N_OUT cells. Per-cell direction flags apply only to sample/toggle
// and to the toggle instruction.
module bte_run_logic
    import bte_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic [N_IN+N_OUT-1:0] cur,
    input  logic [N_IN+N_OUT-1:0] pins,
    input  logic [N_IN+N_OUT-1:0] dir,
    input  logic [OP_W-1:0]       op,
    input  logic                  tog,
    output logic [N_IN+N_OUT-1:0] nxt
);

    localparam int N = N_IN + N_OUT;
    localparam logic [N_OUT-1:0] OUT_TAPS = N_OUT'(lfsr_taps(N_OUT));
    localparam logic [N_IN-1:0]  IN_TAPS  = N_IN'(lfsr_taps(N_IN));

    logic [N_OUT-1:0] out_cur;
    logic [N_IN-1:0]  in_cur;
    logic [N_OUT-1:0] out_pat;
    logic [N_OUT-1:0] out_cnt;
    logic [N_IN-1:0]  in_sig;

    assign out_cur = cur[N-1:N_IN];
    assign in_cur  = cur[N_IN-1:0];
    assign out_cnt = out_cur + N_OUT'(1);

    bte_lfsr_step #(.W(N_OUT), .TAPS(OUT_TAPS)) u_pat (
        .state  (out_cur),
        .inject ('0),
        .next   (out_pat)
    );

    bte_lfsr_step #(.W(N_IN), .TAPS(IN_TAPS)) u_sig (
        .state  (in_cur),
        .inject (pins[N_IN-1:0]),
        .next   (in_sig)
    );

    // Select the step of the active instruction and operation.
    always_comb begin
        nxt = cur;
        if (tog) begin
            nxt = cur ^ dir;
        end else begin
            case (op)
                OP_SIPTOG:  nxt = (dir & ~cur) | (~dir & pins);
                OP_PATGEN:  nxt = {out_pat, in_cur};
                OP_SIG:     nxt = {out_cur, in_sig};
                OP_SIG_PAT: nxt = {out_pat, in_sig};
                OP_SIG_CNT: nxt = {out_cnt, in_sig};
                default:    nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/bte_cell_array.sv
// Array of boundary cells. Each cell has a shift stage clocked on the rising
// edge and a shadow latch clocked on the falling edge. The enables are
// mutually exclusive by TAP state, so the top gives them without priority.
module bte_cell_array #(
    parameter int N = 16
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         shift_en,
    input  logic         run_en,
    input  logic         copy_en,
    input  logic         tdi,
    input  logic [N-1:0] cap_val,
    input  logic [N-1:0] run_val,
    output logic [N-1:0] shift_q,
    output logic [N-1:0] shadow_q
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic ser_in;

        if (i == N - 1) begin : g_head
            assign ser_in = tdi;
        end else begin : g_link
            assign ser_in = shift_q[i+1];
        end

        // Shift stage: capture, serial shift or one run step.
        always_ff @(posedge tck) begin
            if (!rst_n)
                shift_q[i] <= 1'b0;
            else if (cap_en)
                shift_q[i] <= cap_val[i];
            else if (shift_en)
                shift_q[i] <= ser_in;
            else if (run_en)
                shift_q[i] <= run_val[i];
        end

        // Shadow latch: copies the shift stage on the falling edge.
        always_ff @(negedge tck) begin
            if (!rst_n)
                shadow_q[i] <= 1'b0;
            else if (copy_en)
                shadow_q[i] <= shift_q[i];
        end
    end

endmodule

// File: rtl/boundary_test_engine.sv
// Boundary register with a control-register-selected test operation engine.
// It decodes the TAP state and the instruction into capture, shift, update and
// run enables, and selects the register for tdo. Run steps happen only in
// Run-Test/Idle. Assumes tap_state and instr change only between falling and
// rising edges, as an external TAP controller does.
module boundary_test_engine
    import bte_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic                  tck,
    input  logic                  rst_n,
    input  logic [3:0]            tap_state,
    input  logic [2:0]            instr,
    input  logic                  tdi,
    input  logic [N_IN+N_OUT-1:0] pin_in,
    input  logic [N_IN+N_OUT-1:0] cell_dir,
    output logic [N_IN+N_OUT-1:0] pin_out,
    output logic                  tdo
);

    localparam int N = N_IN + N_OUT;

    logic            in_cap, in_sh, in_upd, in_idle;
    logic            bsr_sel, ctrl_sel, byp_sel;
    logic            op_ok, run_en, copy_en;
    logic            byp_q;
    logic [N-1:0]    bsr_shift;
    logic [N-1:0]    cap_val;
    logic [N-1:0]    run_val;
    logic [OP_W-1:0] ctrl_shift;
    logic [OP_W-1:0] ctrl_op;

    // State and instruction decode into per-edge enables.
    always_comb begin
        in_cap   = (tap_state == TAP_CAPTURE);
        in_sh    = (tap_state == TAP_SHIFT);
        in_upd   = (tap_state == TAP_UPDATE);
        in_idle  = (tap_state == TAP_RUN_IDLE);
        bsr_sel  = (instr == INS_SAMPLE) || (instr == INS_READ) ||
                   (instr == INS_SELFTEST);
        ctrl_sel = (instr == INS_CTRL);
        byp_sel  = !bsr_sel && !ctrl_sel;
        op_ok    = (ctrl_op <= OP_SIG_CNT);
        run_en   = in_idle && (((instr == INS_RUN) && op_ok) ||
                               (instr == INS_TOGGLE));
        copy_en  = (in_upd && bsr_sel) || run_en;
    end

    // Capture source of the boundary register for each instruction.
    always_comb begin
        case (instr)
            INS_SAMPLE:   cap_val = pin_in;
            INS_SELFTEST: cap_val = ~pin_out;
            default:      cap_val = bsr_shift;
        endcase
    end

    bte_run_logic #(.N_IN(N_IN), .N_OUT(N_OUT)) u_run (
        .cur  (bsr_shift),
        .pins (pin_in),
        .dir  (cell_dir),
        .op   (ctrl_op),
        .tog  (instr == INS_TOGGLE),
        .nxt  (run_val)
    );

    bte_cell_array #(.N(N)) u_cells (
        .tck      (tck),
        .rst_n    (rst_n),
        .cap_en   (in_cap && bsr_sel),
        .shift_en (in_sh && bsr_sel),
        .run_en   (run_en),
        .copy_en  (copy_en),
        .tdi      (tdi),
        .cap_val  (cap_val),
        .run_val  (run_val),
        .shift_q  (bsr_shift),
        .shadow_q (pin_out)
    );

    bte_ctrl_reg #(.W(OP_W)) u_ctrl (
        .tck     (tck),
        .rst_n   (rst_n),
        .sel     (ctrl_sel),
        .sh      (in_sh),
        .upd     (in_upd),
        .tdi     (tdi),
        .shift_q (ctrl_shift),
        .op_q    (ctrl_op)
    );

    // Bypass stage: loads 0 on capture, takes tdi on shift.
    always_ff @(posedge tck) begin
        if (!rst_n)
            byp_q <= 1'b0;
        else if (byp_sel && in_cap)
            byp_q <= 1'b0;
        else if (byp_sel && in_sh)
            byp_q <= tdi;
    end

    // Serial output: bit 0 of the selected register.
    always_comb begin
        if (bsr_sel)
            tdo = bsr_shift[0];
        else if (ctrl_sel)
            tdo = ctrl_shift[0];
        else
            tdo = byp_q;
    end

endmodule

// File: rtl/bte_checker.sv
// Temporal checks on the boundary test engine, bound to every instance.
// Values are sampled on rising tck. Shadow changes made on the falling edge
// appear at the next rising edge.
module bte_checker
    import bte_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input logic                  tck,
    input logic                  rst_n,
    input logic [3:0]            tap_state,
    input logic [2:0]            instr,
    input logic                  tdi,
    input logic [N_IN+N_OUT-1:0] cell_dir,
    input logic [N_IN+N_OUT-1:0] shift_q,
    input logic [N_IN+N_OUT-1:0] shadow_q,
    input logic [OP_W-1:0]       op_q,
    input logic [OP_W-1:0]       ctrl_q
);

    localparam int N = N_IN + N_OUT;

    logic bsr_on;
    assign bsr_on = (instr == INS_SAMPLE) || (instr == INS_READ) ||
                    (instr == INS_SELFTEST);

    assert_reset_clear_R1: assert property (@(posedge tck)
        !rst_n |=> (shift_q == '0));

    assert_shift_path_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TAP_SHIFT && bsr_on) |=>
        (shift_q == {$past(tdi), $past(shift_q[N-1:1])}));

    assert_shadow_gate_R4: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(shadow_q) |->
        $past(tap_state == TAP_UPDATE || tap_state == TAP_RUN_IDLE));

    assert_ctrl_hold_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TAP_CAPTURE && instr == INS_CTRL) |=> $stable(ctrl_q));

    assert_count_step_R9: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TAP_RUN_IDLE && instr == INS_RUN && op_q == OP_SIG_CNT) |=>
        ((shift_q[N-1:N_IN] - $past(shift_q[N-1:N_IN])) == N_OUT'(1)));

    assert_toggle_mask_R11: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TAP_RUN_IDLE && instr == INS_TOGGLE) |=>
        ((shift_q ^ $past(shift_q)) == $past(cell_dir)));

    assert_hold_state_R13: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state != TAP_CAPTURE && tap_state != TAP_SHIFT &&
         tap_state != TAP_RUN_IDLE) |=> $stable(shift_q));

endmodule

bind boundary_test_engine bte_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .tap_state (tap_state),
    .instr     (instr),
    .tdi       (tdi),
    .cell_dir  (cell_dir),
    .shift_q   (bsr_shift),
    .shadow_q  (pin_out),
    .op_q      (ctrl_op),
    .ctrl_q    (ctrl_shift)
);

// File: tb/boundary_test_engine_test.sv
`timescale 1ns/1ps
module boundary_test_engine_test;
    localparam int NI = 8;
    localparam int NO = 8;
    localparam int N  = NI + NO;

    localparam logic [3:0] S_IDLE = 4'hC, S_CAP = 4'h6, S_SH = 4'h2,
                           S_UPD = 4'h5, S_PAUSE = 4'h3, S_RESET = 4'hF;
    localparam logic [2:0] I_BYP = 3'd0, I_SAMPLE = 3'd1, I_READ = 3'd2,
                           I_SELF = 3'd3, I_RUN = 3'd4, I_TOG = 3'd5, I_CTRL = 3'd6;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   tap_state = S_RESET;
    logic [2:0]   instr = I_BYP;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] cell_dir = '0;
    logic [N-1:0] pin_out;
    logic         tdo;

    int checks = 0;
    int errors = 0;

    always #4 tck = ~tck;

    boundary_test_engine #(.N_IN(NI), .N_OUT(NO)) uut (
        .tck(tck), .rst_n(rst_n), .tap_state(tap_state), .instr(instr),
        .tdi(tdi), .pin_in(pin_in), .cell_dir(cell_dir),
        .pin_out(pin_out), .tdo(tdo)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Inputs are set just after a falling edge; sampling follows the next falling edge.
    task automatic step(input logic [3:0] st, input logic d);
        tap_state = st;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic scan(input logic [N-1:0] din, input int len, output logic [N-1:0] dout);
        dout = '0;
        step(S_CAP, 1'b0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            step(S_SH, din[i]);
        end
        step(S_UPD, 1'b0);
    endtask

    function automatic logic [7:0] pat8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [N-1:0] model(input logic [2:0] op, input bit tog,
                                           input logic [N-1:0] cur,
                                           input logic [N-1:0] pins,
                                           input logic [N-1:0] dir);
        logic [NO-1:0] o;
        logic [NI-1:0] s;
        o = cur[N-1:NI];
        s = pat8(cur[NI-1:0]) ^ pins[NI-1:0];
        if (tog) return cur ^ dir;
        case (op)
            3'd0:    return (dir & ~cur) | (~dir & pins);
            3'd1:    return {pat8(o), cur[NI-1:0]};
            3'd2:    return {o, s};
            3'd3:    return {pat8(o), s};
            3'd4:    return {o + 8'd1, s};
            default: return cur;
        endcase
    endfunction

    task automatic run_case(input logic [2:0] op, input bit tog, input string req,
                            input logic [N-1:0] seed, input logic [N-1:0] pins,
                            input logic [N-1:0] dir, input int cycles);
        logic [N-1:0] d;
        logic [N-1:0] exp;
        instr = I_SAMPLE;
        pin_in = seed;
        scan(seed, N, d);
        if (!tog) begin
            instr = I_CTRL;
            scan(N'(op), 3, d);
        end
        instr = tog ? I_TOG : I_RUN;
        pin_in = pins;
        cell_dir = dir;
        exp = seed;
        for (int c = 0; c < cycles; c++) begin
            step(S_IDLE, 1'b0);
            exp = model(op, tog, exp, pin_in, dir);
            chk(req, "pin_out per idle cycle (R12)", pin_out, exp);
            if (tog) pin_in = pin_in ^ 16'h5A5A;
        end
        step(S_PAUSE, 1'b0);
        chk("R13", "pin_out after leaving idle", pin_out, exp);
        instr = I_READ;
        scan(~exp, N, d);
        chk(req, "read-out of shift stages", d, exp);
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] q;
        logic [N-1:0] b;
        #1;
        for (int i = 0; i < 3; i++) step(S_RESET, 1'b0);
        rst_n = 1'b1;
        chk("R1", "pin_out after reset", pin_out, '0);
        chk("R1", "tdo after reset", N'(tdo), '0);
        instr = I_READ;
        scan(16'h0000, N, d);
        chk("R1", "shift stages after reset", d, '0);

        // Sample capture, shift and update over a sweep of patterns.
        instr = I_SAMPLE;
        for (int k = 0; k < 8; k++) begin
            pin_in = N'(16'h1357 * (k + 1)) ^ N'(k << 11);
            q = N'(16'hC0DE ^ (k * 16'h0931));
            scan(q, N, d);
            chk("R3", "sample capture via tdo (R2 shift)", d, pin_in);
            chk("R4", "update copies shift stages", pin_out, q);
        end

        // Self-test capture loads inverted shadows.
        instr = I_SELF;
        scan(16'h6B2D, N, d);
        chk("R3", "self-test capture", d, ~q);
        chk("R4", "shadow after self-test update", pin_out, 16'h6B2D);

        // Read leaves the shift stages unchanged on capture.
        instr = I_READ;
        scan(16'h1F80, N, d);
        chk("R3", "read capture holds", d, 16'h6B2D);

        // Bypass stage: captures 0, then delays tdi by one cycle.
        instr = I_BYP;
        step(S_CAP, 1'b0);
        chk("R2", "bypass captured zero", N'(tdo), '0);
        step(S_SH, 1'b1);
        chk("R2", "bypass bit 1", N'(tdo), N'(1));
        step(S_SH, 1'b0);
        chk("R2", "bypass bit 0", N'(tdo), '0);
        step(S_UPD, 1'b0);
        chk("R4", "bypass update leaves pins", pin_out, 16'h1F80);

        // Control register scan and hold on capture.
        instr = I_CTRL;
        scan(N'(3'd5), 3, d);
        scan(N'(3'd2), 3, d);
        chk("R5", "control register holds across capture", d, N'(3'd5));

        // Idle steps under a non-run instruction change nothing.
        instr = I_READ;
        for (int i = 0; i < 4; i++) step(S_IDLE, 1'b0);
        chk("R13", "idle under read keeps pins", pin_out, 16'h1F80);
        scan(16'h0, N, d);
        chk("R13", "idle under read keeps stages", d, 16'h1F80);

        // Run operations, including undefined codes.
        for (int op = 0; op < 8; op++) begin
            for (int s = 0; s < 2; s++) begin
                string tag;
                case (op)
                    0: tag = "R10";
                    1: tag = "R6";
                    2: tag = "R7";
                    3: tag = "R8";
                    4: tag = "R9";
                    default: tag = "R13";
                endcase
                b = N'(16'hACE1 ^ (op * 16'h1111) ^ (s * 16'h0F0F));
                run_case(3'(op), 1'b0, tag, b, N'(16'h3C5A ^ op),
                         N'(16'h0FF0 ^ (s * 16'hAAAA)), 5 + op + s * 7);
            end
        end

        // Count wrap from all-ones to zero.
        run_case(3'd4, 1'b0, "R9", 16'hFE5A, 16'h0077, 16'h0000, 4);
        run_case(3'd4, 1'b0, "R9", 16'hFF00, 16'h0000, 16'h0000, 1);

        // Toggle instruction with pins changing every cycle.
        run_case(3'd0, 1'b1, "R11", 16'h9C36, 16'h0F0F, 16'hA5C3, 7);
        run_case(3'd0, 1'b1, "R11", 16'h0000, 16'hFFFF, 16'h0001, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule